// File: doc/BRIEF.md
# Output-Stationary Multiply-Accumulate Grid with Rectified Byte Drain

This block multiplies two square signed 8-bit matrices on a grid of multiply-accumulate cells. Every cell owns one entry of the product. Left-edge operands move one cell to the right per cycle, and top-edge operands move one cell down per cycle, so matching terms meet in the right cell. The caller starts a product with a one-cycle `start` pulse. In that cycle and in the six cycles after it, the caller drives the edges in skewed order: in cycle c after the start (the start cycle is c = 0), row i of `a_west` carries A[i][c-i] and column j of `b_north` carries B[c-j][j]. When an index falls outside 0..3, the caller drives zero. Edge values are captured only in cycles 0 through 6.

A control state machine sequences the work. The states are IDLE, FILL, DRAIN and DONE. IDLE goes to FILL when `start` is high. FILL goes to DRAIN at the end of cycle 4, when the first cell holds its finished sum. DRAIN visits the seven anti-diagonals in turn and spends four cycles on each. It goes to DONE after the last slot of the last diagonal. DONE lasts one cycle and then returns to IDLE. In each occupied slot, one cell's sum is read and passes through a rectifier that clamps it to 0..255. The result is sent as a byte with a valid strobe. The cell's accumulator is cleared in the same cycle it is read.

Top module: `sa_relu_grid`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `out_valid`, `busy` and `done` are 0 and `out_data` is 0.
- R2: Every byte sent equals the clamped value of C[i][j] = sum over k of A[i][k]*B[k][j], with all operands taken as signed 8-bit values. Sums are exact up to 20 bits.
- R3: A negative sum is sent as 0.
- R4: A sum above 255 is sent as 255.
- R5: Diagonal d (d = i+j) is sent in the four cycles from 6+4d. Its cells go in increasing row order, one per cycle, starting in the first cycle of the slot. The cycles of a slot that have no cell carry `out_valid` = 0.
- R6: Each product gives exactly 16 bytes with `out_valid` high, and no byte is sent while `busy` is low.
- R7: `done` is high only in cycle 33, as a one-cycle pulse, after the last byte has been sent.
- R8: A `start` pulse while `busy` is high has no effect on the byte stream or on timing.
- R9: After `done`, every accumulator holds zero, so a product started right away gives results that do not depend on the previous product.
- R10: Edge operand values driven outside cycles 0 through 6 of a product are not used.
- R11: `busy` is high from cycle 1 through cycle 33 and rises only after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a product when the block is idle |
| a_west | input | DIM*DW | Left-edge operands, row i at bits [i*DW +: DW] |
| b_north | input | DIM*DW | Top-edge operands, column j at bits [j*DW +: DW] |
| out_data | output | OW | Rectified, clamped result byte |
| out_valid | output | 1 | `out_data` holds a result this cycle |
| busy | output | 1 | A product is in progress |
| done | output | 1 | One-cycle pulse once all diagonals are drained |

## Verification
The checker enforces a set of properties on every cycle:
- a result strobe only appears while the block is busy;
- the completion pulse lasts one cycle and never coincides with a result;
- every accumulator is zero at completion;
- exactly sixteen strobes arrive per product;
- busy rises only after an accepted start.

Some behaviour can only be shown by the bench's scenarios, which compare results against a reference product:
- the numeric value of each byte, including the negative-to-zero and above-255 clamps;
- the exact slot timing within each diagonal;
- that late operand noise and a repeated start leave the stream unchanged.

// File: rtl/sa_grid_pkg.sv
`timescale 1ns/1ps
package sa_grid_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } grid_state_t;
endpackage

// File: rtl/sa_mac_cell.sv
`timescale 1ns/1ps
module sa_mac_cell #(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_in,
    input  logic signed [DW-1:0] b_in,
    input  logic                 clr,
    output logic signed [DW-1:0] a_out,
    output logic signed [DW-1:0] b_out,
    output logic signed [AW-1:0] acc_out
);
    logic signed [DW-1:0]   a_q;
    logic signed [DW-1:0]   b_q;
    logic signed [AW-1:0]   acc_q;
    logic signed [2*DW-1:0] prod;

    // The product is taken from the registered operands, and the same
    // registers feed the neighbouring cells.
    assign prod = a_q * b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
        end else begin
            a_q <= a_in;
            b_q <= b_in;
            // Reading a cell's sum clears it, so the next product starts at zero.
            if (clr) acc_q <= '0;
            else     acc_q <= acc_q + AW'(prod);
        end
    end

    assign a_out   = a_q;
    assign b_out   = b_q;
    assign acc_out = acc_q;
endmodule

// File: rtl/sa_drain_seq.sv
`timescale 1ns/1ps
module sa_drain_seq
    import sa_grid_pkg::*;
#(
    parameter int DIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic cap_en,
    output logic fire,
    output logic [((DIM > 1) ? $clog2(DIM) : 1)-1:0] sel_row,
    output logic [((DIM > 1) ? $clog2(DIM) : 1)-1:0] sel_col,
    output logic busy,
    output logic done
);
    localparam int PW        = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int NDIAG     = 2 * DIM - 1;
    localparam int DGW       = $clog2(NDIAG + 1);
    localparam int LAST_TICK = DIM + 1 + NDIAG * DIM;
    localparam int TICK_W    = $clog2(LAST_TICK + 2);
    localparam logic [TICK_W-1:0] FEED_LAST = TICK_W'(2 * DIM - 2);
    localparam logic [TICK_W-1:0] FILL_LAST = TICK_W'(DIM);
    localparam logic [DGW-1:0]    DIAG_END  = DGW'(NDIAG - 1);
    localparam logic [PW-1:0]     SLOT_END  = PW'(DIM - 1);

    grid_state_t       state_q, state_d;
    logic [TICK_W-1:0] tick_q;
    logic [DGW-1:0]    diag_q;
    logic [PW-1:0]     pos_q;
    int                len_i, base_i;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FILL;
            ST_FILL:  if (tick_q == FILL_LAST) state_d = ST_DRAIN;
            ST_DRAIN: if (diag_q == DIAG_END && pos_q == SLOT_END) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // Counters: cycles since start, diagonal index, slot within the diagonal.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            diag_q <= '0;
            pos_q  <= '0;
        end else begin
            if (state_q == ST_IDLE) tick_q <= start ? TICK_W'(1) : '0;
            else                    tick_q <= tick_q + TICK_W'(1);
            if (state_q == ST_DRAIN) begin
                if (pos_q == SLOT_END) begin
                    pos_q  <= '0;
                    diag_q <= diag_q + DGW'(1);
                end else begin
                    pos_q <= pos_q + PW'(1);
                end
            end else begin
                pos_q  <= '0;
                diag_q <= '0;
            end
        end
    end

    // Length of the current diagonal and its first row.
    always_comb begin
        if (int'(diag_q) < DIM) begin
            len_i  = int'(diag_q) + 1;
            base_i = 0;
        end else begin
            len_i  = NDIAG - int'(diag_q);
            base_i = int'(diag_q) - DIM + 1;
        end
    end

    // Outputs.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        cap_en  = (state_q == ST_IDLE) ? start : (tick_q <= FEED_LAST);
        fire    = (state_q == ST_DRAIN) && (int'(pos_q) < len_i);
        sel_row = PW'(base_i + int'(pos_q));
        sel_col = PW'(int'(diag_q) - base_i - int'(pos_q));
    end
endmodule

// File: rtl/sa_relu_grid.sv
`timescale 1ns/1ps
module sa_relu_grid #(
    parameter int DIM = 4,
    parameter int DW  = 8,
    parameter int AW  = 20,
    parameter int OW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM*DW-1:0] a_west,
    input  logic [DIM*DW-1:0] b_north,
    output logic [OW-1:0]     out_data,
    output logic              out_valid,
    output logic              busy,
    output logic              done
);
    localparam int PW = (DIM > 1) ? $clog2(DIM) : 1;
    localparam logic signed [AW-1:0] OUT_MAX = AW'((1 << OW) - 1);

    logic                 cap_en, fire;
    logic [PW-1:0]        sel_row, sel_col;
    logic signed [DW-1:0] a_link [DIM][DIM+1];
    logic signed [DW-1:0] b_link [DIM+1][DIM];
    logic signed [AW-1:0] acc_cell [DIM][DIM];
    logic [DIM*DIM*AW-1:0] acc_flat;
    logic [DIM*DW-1:0]    unused_a_edge, unused_b_edge;
    logic signed [AW-1:0] sel_acc;
    logic [OW-1:0]        clamp_val;

    sa_drain_seq #(.DIM(DIM)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cap_en  (cap_en),
        .fire    (fire),
        .sel_row (sel_row),
        .sel_col (sel_col),
        .busy    (busy),
        .done    (done)
    );

    genvar r, c;
    generate
        for (r = 0; r < DIM; r++) begin : g_edge
            // Edge values are passed in only during the feed window.
            assign a_link[r][0]   = cap_en ? a_west[r*DW +: DW]  : '0;
            assign b_link[0][r]   = cap_en ? b_north[r*DW +: DW] : '0;
            assign unused_a_edge[r*DW +: DW] = a_link[r][DIM];
            assign unused_b_edge[r*DW +: DW] = b_link[DIM][r];
        end
        for (r = 0; r < DIM; r++) begin : g_row
            for (c = 0; c < DIM; c++) begin : g_col
                sa_mac_cell #(.DW(DW), .AW(AW)) u_cell (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .a_in    (a_link[r][c]),
                    .b_in    (b_link[r][c]),
                    .clr     (fire && sel_row == PW'(r) && sel_col == PW'(c)),
                    .a_out   (a_link[r][c+1]),
                    .b_out   (b_link[r+1][c]),
                    .acc_out (acc_cell[r][c])
                );
                assign acc_flat[(r*DIM+c)*AW +: AW] = acc_cell[r][c];
            end
        end
    endgenerate

    assign sel_acc = acc_cell[sel_row][sel_col];

    // Rectify and clamp to the output range.
    always_comb begin
        if (sel_acc < 0)            clamp_val = '0;
        else if (sel_acc > OUT_MAX) clamp_val = '1;
        else                        clamp_val = sel_acc[OW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_data <= clamp_val;
        end
    end
endmodule

// File: rtl/sa_relu_grid_chk.sv
`timescale 1ns/1ps
module sa_relu_grid_chk #(
    parameter int DIM = 4,
    parameter int AW  = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic                  out_valid,
    input logic [DIM*DIM*AW-1:0] acc_flat
);
    int byte_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         byte_cnt <= 0;
        else if (!busy)     byte_cnt <= 0;
        else if (out_valid) byte_cnt <= byte_cnt + 1;
    end

    assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    assert_byte_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_cnt == DIM * DIM));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
    assert_acc_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_flat == '0));
    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind sa_relu_grid sa_relu_grid_chk #(.DIM(DIM), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .acc_flat  (acc_flat)
);

// File: tb/sa_relu_grid_tb_top.sv
`timescale 1ns/1ps
module sa_relu_grid_tb_top;
    localparam int DIM = 4;
    localparam int DW  = 8;
    // Each entry holds A row-major, then B row-major. Byte k is at [255-8k -: 8].
    localparam logic [255:0] VEC_TABLE [4] = '{
        256'h01000000_00020000_00000300_00000004_01020304_05060708_090a0b0c_0d0e0f10,
        256'h01ff02fe_03fd04fc_f9070a0b_80017f02_02030405_ff01fe02_0304fbfa_11f0220e,
        256'h0f000000_10000000_7f7f7f7f_80808080_11ff7f80_7f7f7f7f_80808080_01010101,
        256'h80808080_80808080_80808080_80808080_80808080_80808080_80808080_80808080
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIM*DW-1:0] a_west = '0;
    logic [DIM*DW-1:0] b_north = '0;
    logic [7:0]        out_data;
    logic              out_valid, busy, done;
    int                n_checks = 0;
    int                n_errors = 0;

    always #10 clk = ~clk;

    sa_relu_grid dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .a_west(a_west), .b_north(b_north),
        .out_data(out_data), .out_valid(out_valid), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int opnd(input logic [255:0] v, input int idx);
        logic signed [7:0] b;
        b = v[255 - 8*idx -: 8];
        return int'(b);
    endfunction

    // Run one product. noise: junk on the edges after cycle 6 (R10).
    // extra: repeated start pulses while busy (R8).
    task automatic run_product(input logic [255:0] v, input bit noise, input bit extra);
        int raw [DIM][DIM];
        int valid_seen = 0;
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                raw[i][j] = 0;
                for (int k = 0; k < DIM; k++)
                    raw[i][j] += opnd(v, i*DIM + k) * opnd(v, 16 + k*DIM + j);
            end
        for (int c = 0; c <= 34; c++) begin
            @(negedge clk);
            begin
                int s = c - 6;
                bit ev = 0;
                int er = 0, ec = 0;
                if (s >= 0 && s < 28) begin
                    int d = s / 4;
                    int p = s % 4;
                    int len = (d < DIM) ? d + 1 : 7 - d;
                    int base = (d < DIM) ? 0 : d - DIM + 1;
                    if (p < len) begin
                        ev = 1; er = base + p; ec = d - er;
                    end
                end
                check(out_valid == ev, "R5 valid slot", out_valid, ev);
                if (out_valid) valid_seen++;
                if (ev && out_valid) begin
                    int rv = raw[er][ec];
                    int ex = (rv < 0) ? 0 : ((rv > 255) ? 255 : rv);
                    string tag = (rv < 0) ? "R3 negative clamp" :
                                 ((rv > 255) ? "R4 upper clamp" : "R2 product value");
                    check(out_data == 8'(ex), tag, out_data, ex);
                end
                check(busy == (c >= 1 && c <= 33), extra ? "R8 busy timing" : "R11 busy timing",
                      busy, (c >= 1 && c <= 33));
                check(done == (c == 33), "R7 done pulse", done, (c == 33));
            end
            start = (c == 0) || (extra && (c == 10 || c == 33));
            for (int i = 0; i < DIM; i++) begin
                int ka = c - i;
                int kb = c - i;
                a_west[i*DW +: DW]  = (ka >= 0 && ka < DIM) ? 8'(opnd(v, i*DIM + ka)) :
                                      ((noise && c > 6) ? 8'(c*37 + i*11 + 1) : 8'h00);
                b_north[i*DW +: DW] = (kb >= 0 && kb < DIM) ? 8'(opnd(v, 16 + kb*DIM + i)) :
                                      ((noise && c > 6) ? 8'(c*53 + i*7 + 3) : 8'h00);
            end
            if (c == 34) begin
                start = 0; a_west = '0; b_north = '0;
            end
        end
        check(valid_seen == 16, "R6 byte count", valid_seen, 16);
    endtask

    initial begin
        #4000000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int e0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R1 reset valid", out_valid, 0);
        check(busy == 0, "R1 reset busy", busy, 0);
        check(done == 0, "R1 reset done", done, 0);
        check(out_data == 0, "R1 reset data", out_data, 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && out_valid == 0, "R1 after release", busy, 0);

        for (int t = 0; t < 4; t++) run_product(VEC_TABLE[t], 0, 0);

        e0 = n_errors;
        run_product(VEC_TABLE[1], 1, 0);
        check(n_errors == e0, "R10 late operands ignored", n_errors - e0, 0);

        e0 = n_errors;
        run_product(VEC_TABLE[2], 0, 1);
        check(n_errors == e0, "R8 start while busy ignored", n_errors - e0, 0);

        e0 = n_errors;
        run_product(VEC_TABLE[3], 0, 0);
        run_product(VEC_TABLE[0], 0, 0);
        check(n_errors == e0, "R9 back-to-back independent", n_errors - e0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule